// File: doc/BRIEF.md
# Parameter Page CRC-16 Checker

This block checks the integrity of one copy of a NAND flash parameter page while the copy streams past it. The host side presents the 256-byte copy one byte per clock on a byte bus qualified by a valid strobe. The checker runs a CRC-16 over every byte except the final two. It keeps those two bytes as the stored check value and compares the two once the last byte has arrived.

A start pulse clears the byte position and reloads the CRC seed, either before a copy or to abandon one half way through. When the 256th byte is accepted, the block raises a one-cycle done pulse and updates a pass flag. The running CRC value is always visible on an output. Copies may also follow each other with no start pulse between them: the byte after a completed copy is taken as byte 0 of a new copy, and the CRC is seeded again for it.

Top module: `pp_crc_checker`

## Requirements
- R1: The CRC uses the generator 0x8005 (x^16 + x^15 + x^2 + 1). Each byte is shifted in most significant bit first, with no reflection of the data or of the CRC, and no final XOR. After an accepted byte, crc_o shows the updated value on the following cycle.
- R2: After reset, and on the cycle after a start pulse, crc_o reads 0x4F4E. Byte 0 of every copy is folded into the seed 0x4F4E.
- R3: Only byte positions 0 to 253 update the CRC. Accepting positions 254 and 255 leaves crc_o unchanged.
- R4: The stored value is byte 254 as the low half and byte 255 as the high half; for example, 80h then 3Eh means 0x3E80. pass_o is 1 after a copy whose computed CRC equals the stored value.
- R5: pass_o is 0 after a copy where either stored byte, or any protected byte, makes the two values differ.
- R6: done_o is 1 for exactly one cycle: the cycle after byte position 255 is accepted. It is 0 out of reset.
- R7: Cycles with valid_i low change neither the byte position nor the CRC.
- R8: A start pulse during a copy resets the position to 0 and the CRC to the seed. A byte presented with valid_i in the same cycle as start_i is dropped.
- R9: With no start pulse, the byte accepted after position 255 is position 0 of a new copy.
- R10: pass_o is 0 out of reset. It keeps its value until the next copy completes. A start pulse clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Clears the byte position, the CRC seed and the pass flag |
| valid_i | input | 1 | Qualifies byte_i for the current cycle |
| byte_i | input | 8 | Parameter page byte |
| done_o | output | 1 | One-cycle pulse after the last byte of a copy |
| pass_o | output | 1 | Computed CRC matched the stored CRC for the last completed copy |
| crc_o | output | 16 | Current CRC register value |

## Verification
Every result of this block comes from a single register stage. crc_o, done_o and pass_o therefore take their new values on the rising edge that accepts a byte or a start pulse, and are due one cycle after the inputs were driven. The only exception is right after reset: the internal reset release adds two cycles, and the bench waits them out before driving anything. The bench drives inputs and samples outputs on the falling edge. A behavioural model in the bench is advanced on each rising edge, so each falling-edge comparison checks the outputs due from the edge just taken. Directed checks read the results at the same falling edge after the last byte, then one cycle later to confirm the pulse has ended.

// File: rtl/pp_crc_pkg.sv
package pp_crc_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CRC_W  = 16;

  // Fold one byte into the CRC, most significant bit first, no reflection.
  function automatic logic [CRC_W-1:0] crc_fold_byte(
    input logic [CRC_W-1:0]  cur,
    input logic [BYTE_W-1:0] din,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] r;
    logic             fb;
    r = cur;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ din[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) begin
        r = r ^ poly;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/pp_rst_sync.sv
module pp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pp_byte_tracker.sv
module pp_byte_tracker #(
  parameter int unsigned PAGE_BYTES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  output logic feed_o,
  output logic first_o,
  output logic cap_lo_o,
  output logic cap_hi_o
);

  localparam int unsigned CNT_W  = $clog2(PAGE_BYTES);
  localparam int unsigned LAST   = PAGE_BYTES - 1;
  localparam int unsigned LO_IDX = PAGE_BYTES - 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             accept;
  logic             at_last;

  assign accept  = valid_i & ~start_i;
  assign at_last = (cnt_q == CNT_W'(LAST));

  always_comb begin
    cnt_en = start_i | accept;
    if (start_i) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign feed_o   = accept & (cnt_q < CNT_W'(LO_IDX));
  assign first_o  = accept & (cnt_q == '0);
  assign cap_lo_o = accept & (cnt_q == CNT_W'(LO_IDX));
  assign cap_hi_o = accept & at_last;

  // R9: the position after the last byte is position 0 of the next copy
  p_wrap_to_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hi_o |=> (cnt_q == '0));

  // R7: idle cycles leave the position alone
  p_idle_holds_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !start_i) |=> $stable(cnt_q));

  // R8: start returns to position 0
  p_start_clears_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == '0));

endmodule

// File: rtl/pp_crc_engine.sv
module pp_crc_engine
  import pp_crc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h8005,
  parameter logic [CRC_W-1:0] SEED = 16'h4F4E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              feed_i,
  input  logic              first_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] base;
  logic             crc_en;

  always_comb begin
    base   = first_i ? SEED : crc_q;
    crc_en = start_i | feed_i;
    if (start_i) begin
      crc_d = SEED;
    end else begin
      crc_d = crc_fold_byte(base, byte_i, POLY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= SEED;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;

  // R2: a start pulse reloads the seed
  p_seed_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (crc_q == SEED));

  // R3: no feed, no change
  p_hold_without_feed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!feed_i && !start_i) |=> $stable(crc_q));

endmodule

// File: rtl/pp_verdict.sv
module pp_verdict
  import pp_crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              done_o,
  output logic              pass_o
);

  logic [BYTE_W-1:0] lo_q;
  logic              done_q;
  logic              done_d;
  logic              pass_q;
  logic              pass_d;
  logic              pass_en;
  logic [CRC_W-1:0]  stored;

  always_comb begin
    stored  = {byte_i, lo_q};
    done_d  = cap_hi_i;
    pass_en = start_i | cap_hi_i;
    pass_d  = start_i ? 1'b0 : (crc_i == stored);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (cap_lo_i) begin
      lo_q <= byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (pass_en) begin
        pass_q <= pass_d;
      end
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;

  // R6: done never lasts two cycles
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: start clears the verdict
  p_start_clears_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !pass_q);

  // R10: verdict only moves on completion or start
  p_pass_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !cap_hi_i) |=> $stable(pass_q));

endmodule

// File: rtl/pp_crc_checker.sv
module pp_crc_checker
  import pp_crc_pkg::*;
#(
  parameter int unsigned      PAGE_BYTES = 256,
  parameter logic [CRC_W-1:0] POLY       = 16'h8005,
  parameter logic [CRC_W-1:0] SEED       = 16'h4F4E
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [CRC_W-1:0]  crc_o
);

  logic rst_sync_n;
  logic feed;
  logic first;
  logic cap_lo;
  logic cap_hi;

  pp_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk_i),
    .rst_async_n (rst_n_i),
    .rst_sync_n  (rst_sync_n)
  );

  pp_byte_tracker #(.PAGE_BYTES(PAGE_BYTES)) u_track (
    .clk      (clk_i),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .valid_i  (valid_i),
    .feed_o   (feed),
    .first_o  (first),
    .cap_lo_o (cap_lo),
    .cap_hi_o (cap_hi)
  );

  pp_crc_engine #(.POLY(POLY), .SEED(SEED)) u_crc (
    .clk     (clk_i),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .feed_i  (feed),
    .first_i (first),
    .byte_i  (byte_i),
    .crc_o   (crc_o)
  );

  pp_verdict u_verdict (
    .clk      (clk_i),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .cap_lo_i (cap_lo),
    .cap_hi_i (cap_hi),
    .byte_i   (byte_i),
    .crc_i    (crc_o),
    .done_o   (done_o),
    .pass_o   (pass_o)
  );

  // R3: the two stored-value bytes do not disturb the CRC
  p_tail_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (cap_lo || cap_hi) |=> $stable(crc_o));

  // R6: done only follows an accepted byte
  p_done_after_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    done_o |-> ($past(valid_i) && !$past(start_i)));

  // R7: idle input leaves the CRC alone
  p_idle_crc_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!valid_i && !start_i) |=> $stable(crc_o));

endmodule

// File: tb/pp_crc_checker_tb_top.sv
module pp_crc_checker_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        valid;
  logic [7:0]  byte_in;
  logic        done;
  logic        pass;
  logic [15:0] crc;

  int vectors;
  int miscompares;
  bit finished;

  logic [7:0] page [256];

  // behavioural reference state
  int          m_cnt;
  logic [15:0] m_crc;
  logic [7:0]  m_lo;
  logic        m_done;
  logic        m_pass;

  pp_crc_checker dut_i (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .start_i (start),
    .valid_i (valid),
    .byte_i  (byte_in),
    .done_o  (done),
    .pass_o  (pass),
    .crc_o   (crc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int ref_step(int r, int b);
    int v;
    v = r;
    for (int k = 7; k >= 0; k--) begin
      int top;
      top = ((v >> 15) ^ (b >> k)) & 1;
      v = (v * 2) & 32'hFFFF;
      if (top != 0) v = v ^ 32'h8005;
    end
    return v;
  endfunction

  function automatic int page_crc();
    int r;
    r = 32'h4F4E;
    for (int i = 0; i < 254; i++) r = ref_step(r, int'(page[i]));
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_crc = 16'h4F4E; m_lo = 8'h00; m_done = 1'b0; m_pass = 1'b0;
    end else if (start) begin
      m_cnt = 0; m_crc = 16'h4F4E; m_done = 1'b0; m_pass = 1'b0;
    end else if (valid) begin
      m_done = (m_cnt == 255);
      if (m_cnt == 255) m_pass = (m_crc == {byte_in, m_lo});
      if (m_cnt == 254) m_lo = byte_in;
      if (m_cnt < 254) m_crc = 16'(ref_step((m_cnt == 0) ? 32'h4F4E : int'(m_crc), int'(byte_in)));
      m_cnt = (m_cnt + 1) % 256;
    end else begin
      m_done = 1'b0;
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1 crc_o model", int'(crc), int'(m_crc));
      check("R6 done_o model", int'(done), int'(m_done));
      check("R4 pass_o model", int'(pass), int'(m_pass));
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(logic [7:0] b);
    valid = 1'b1; byte_in = b;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_page(bit gaps);
    for (int i = 0; i < 256; i++) begin
      send(page[i]);
      if (gaps && (i % 7 == 3) && i != 255) idle(1);
    end
  endtask

  task automatic build(int kind);
    int c;
    int x;
    x = 32'h1D;
    for (int i = 0; i < 254; i++) begin
      if (kind == 0) page[i] = 8'h00;
      else if (kind == 1) page[i] = 8'(i);
      else begin
        x = (x * 69069 + 1) & 32'h7FFFFFFF;
        page[i] = 8'(x >> 11);
      end
    end
    c = page_crc();
    page[254] = 8'(c);
    page[255] = 8'(c >> 8);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [15:0] held;
    int          exp;
    vectors = 0; miscompares = 0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0; valid = 1'b0; byte_in = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R2 R6 R10: reset state
    check("R2 reset crc", int'(crc), 32'h4F4E);
    check("R6 reset done", int'(done), 0);
    check("R10 reset pass", int'(pass), 0);

    // R1 R4 R7: good ramp page with idle gaps
    build(1);
    exp = page_crc();
    pulse_start();
    send_page(1'b1);
    check("R6 done after last", int'(done), 1);
    check("R4 pass good ramp", int'(pass), 1);
    check("R1 crc ramp", int'(crc), exp);
    idle(1);
    check("R6 done one cycle", int'(done), 0);

    // R10: verdict held while idle, then cleared by start
    idle(3);
    check("R10 pass held", int'(pass), 1);
    pulse_start();
    check("R10 pass cleared", int'(pass), 0);
    check("R2 seed after start", int'(crc), 32'h4F4E);

    // R5: corrupted stored low, stored high, and protected byte
    page[254] = page[254] ^ 8'h01;
    send_page(1'b0);
    check("R5 bad low byte", int'(pass), 0);
    page[254] = page[254] ^ 8'h01;
    page[255] = page[255] ^ 8'h80;
    send_page(1'b0);
    check("R5 bad high byte", int'(pass), 0);
    page[255] = page[255] ^ 8'h80;
    page[10] = page[10] ^ 8'h04;
    send_page(1'b0);
    check("R5 bad data byte", int'(pass), 0);
    page[10] = page[10] ^ 8'h04;

    // R3 R7: tail bytes and idle cycles leave the CRC unchanged
    pulse_start();
    for (int i = 0; i < 254; i++) send(page[i]);
    held = crc;
    check("R1 crc before tail", int'(held), page_crc());
    idle(4);
    check("R7 idle holds crc", int'(crc), int'(held));
    send(page[254]);
    check("R3 byte 254 no fold", int'(crc), int'(held));
    send(page[255]);
    check("R3 byte 255 no fold", int'(crc), int'(held));
    check("R4 pass direct", int'(pass), 1);

    // R8: restart mid copy, then start together with valid
    build(2);
    for (int i = 0; i < 100; i++) send(8'(i * 3));
    pulse_start();
    check("R8 seed after mid start", int'(crc), 32'h4F4E);
    start = 1'b1; valid = 1'b1; byte_in = 8'hAA;
    @(negedge clk);
    start = 1'b0; valid = 1'b0;
    check("R8 byte with start dropped", int'(crc), 32'h4F4E);
    send_page(1'b1);
    check("R8 pass after restart", int'(pass), 1);
    check("R6 done after restart", int'(done), 1);

    // R9: back-to-back copies without start
    build(0);
    send_page(1'b0);
    check("R9 first copy pass", int'(pass), 1);
    build(2);
    send_page(1'b0);
    check("R9 second copy pass", int'(pass), 1);
    check("R1 crc second copy", int'(crc), page_crc());

    idle(3);
    summary();
  end

endmodule